// File: doc/BRIEF.md
# Half-Flash Converter Interface Sequencer

This block is the device-side digital sequencer of a two-step 8-bit converter, written as a synthesizable bus-functional model. Host controllers can be tested against it without any analog parts. The comparators are replaced by two 4-bit stub inputs, one for the upper result and one for the lower result. The time the lower conversion takes is a fixed number of clock cycles. All strobe inputs are active low and are sampled on the rising clock edge. An edge counts when it shows up between two consecutive samples.

The mode input picks one of two host handshakes.

- **Read-strobe mode (mode low):** a falling read strobe both starts the conversion and later fetches the result. A drive-low ready output tells the host when the word can be taken.
- **Write-read mode (mode high):** a falling write strobe starts tracking. The rising write strobe latches the upper nibble and starts the lower conversion. The host then reads whenever it chooses.

In both modes the interrupt output falls when the whole word is latched. The 8-bit data bus is modelled as a value plus a drive enable.

Top module: `halfflash_seq`

## Requirements
- R1: Out of reset, `intN` is 1, `rdyLowEn` is 0, `dataOe` is 0 and the held word is 0x00.
- R2: With `modeSel`=0 and `csN` low, a sampled falling `rdN` starts a conversion. At that edge, `hiNib` is latched into bits 7:4 of the held word.
- R3: With `modeSel`=1 and `csN` low, a sampled falling `wrN` arms the sequencer. The next sampled rising `wrN` latches `hiNib` into bits 7:4 and starts the lower conversion.
- R4: LO_CYCLES clock edges after the edge that latched the upper nibble, `loNib` is latched into bits 3:0 and `intN` goes low on that same edge.
- R5: With `modeSel`=0, `rdyLowEn` asserts on the edge that samples a falling `csN`. It clears on the edge where the conversion ends or where a rising `csN` is sampled, and clearing wins over asserting.
- R6: `intN` returns to 1 on the edge that samples a rising `csN` or a rising `rdN`, unless a conversion ends on that same edge.
- R7: With `modeSel`=1, `dataOe` follows (`csN` low and `rdN` low) combinationally, and `dataOut` then shows the held word, even while the lower conversion runs.
- R8: With `modeSel`=0, the bus drives only while `csN` and `rdN` are low and the conversion started last has finished.
- R9: While `pwrDn` is 1, strobes are ignored, any running conversion is abandoned, `intN` is held at 1, and `rdyLowEn` and `dataOe` are 0. The held word keeps its value.
- R10: The following are all ignored:
  - strobes while `csN` is high;
  - a rising `wrN` without an armed falling edge;
  - start edges while a lower conversion is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe (write-read mode) |
| modeSel | input | 1 | 0 selects read-strobe mode, 1 selects write-read mode |
| pwrDn | input | 1 | Power-down, active high |
| hiNib | input | 4 | Stub upper flash result |
| loNib | input | 4 | Stub lower flash result |
| rdyLowEn | output | 1 | Ready pin pull-low enable (open drain, no internal pull-up) |
| intN | output | 1 | Active-low end-of-conversion interrupt |
| dataOut | output | 8 | Data bus value, 0 when not driven |
| dataOe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with LO_CYCLES=3, which keeps the lower conversion window short. With that setting, each of these falls within a few cycles of the start:

- a read during the lower conversion in write-read mode, which shows the new upper nibble next to the stale lower one;
- a change of the lower stub input in mid-conversion, which shows that the lower nibble is sampled on the final edge;
- a power-down that lands inside the window.

A behavioural model in the bench tracks the interrupt, the ready enable, the bus enable and the bus value on every clock.

// File: rtl/halfflash_pkg.sv
package halfflash_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic latchHi;
    logic latchLo;
    logic driveBus;
  } seqCtl_t;
endpackage

// File: rtl/halfflash_ctrl.sv
module halfflash_ctrl
  import halfflash_pkg::*;
#(
  parameter int LO_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    rdN,
  input  logic    wrN,
  input  logic    modeSel,
  input  logic    pwrDn,
  output seqCtl_t ctl,
  output logic    rdyLowEn,
  output logic    intN
);
  localparam int CNT_W = $clog2(LO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LO_CYCLES - 1);

  logic csQ, rdQ, wrQ;
  logic busyLo, wrArmed, doneQ, rdyQ, intQ;
  logic [CNT_W-1:0] loCnt;

  logic csFall, csRise, rdFall, rdRise, wrFall, wrRise;
  logic startRd, armWr, startWr, finish;

  assign csFall = csQ & ~csN;
  assign csRise = ~csQ & csN;
  assign rdFall = rdQ & ~rdN;
  assign rdRise = ~rdQ & rdN;
  assign wrFall = wrQ & ~wrN;
  assign wrRise = ~wrQ & wrN;

  assign startRd = ~pwrDn & ~modeSel & rdFall & ~csN & ~busyLo;
  assign armWr   = ~pwrDn & modeSel & wrFall & ~csN & ~busyLo;
  assign startWr = ~pwrDn & modeSel & wrRise & wrArmed;
  assign finish  = ~pwrDn & busyLo & (loCnt == '0);

  // Edge history keeps running in power-down so no stale edge appears on exit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= 1'b1;
      rdQ <= 1'b1;
      wrQ <= 1'b1;
    end else begin
      csQ <= csN;
      rdQ <= rdN;
      wrQ <= wrN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyLo  <= 1'b0;
      wrArmed <= 1'b0;
      doneQ   <= 1'b0;
      loCnt   <= '0;
    end else if (pwrDn) begin
      busyLo  <= 1'b0;
      wrArmed <= 1'b0;
      doneQ   <= 1'b0;
      loCnt   <= '0;
    end else begin
      if (armWr) begin
        wrArmed <= 1'b1;
        doneQ   <= 1'b0;
      end
      if (startWr || startRd) begin
        wrArmed <= 1'b0;
        busyLo  <= 1'b1;
        loCnt   <= CNT_LOAD;
        doneQ   <= 1'b0;
      end else if (busyLo) begin
        if (finish) begin
          busyLo <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          loCnt <= loCnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intQ <= 1'b1;
      rdyQ <= 1'b0;
    end else if (pwrDn) begin
      intQ <= 1'b1;
      rdyQ <= 1'b0;
    end else begin
      if (finish)               intQ <= 1'b0;
      else if (csRise | rdRise) intQ <= 1'b1;
      if (finish | csRise)          rdyQ <= 1'b0;
      else if (~modeSel & csFall)   rdyQ <= 1'b1;
    end
  end

  assign ctl.latchHi  = startRd | startWr;
  assign ctl.latchLo  = finish;
  assign ctl.driveBus = ~pwrDn & ~csN & ~rdN & (modeSel | doneQ);
  assign rdyLowEn     = rdyQ;
  assign intN         = intQ;

  initial begin
    assert (LO_CYCLES >= 1) else $error("LO_CYCLES must be at least 1");
  end

  AST_INT_HIGH_IN_PD: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |=> intN); // R9
  AST_RDY_OFF_IN_PD: assert property (@(posedge clk) disable iff (!rstN)
    pwrDn |=> !rdyLowEn); // R9
  AST_INT_FALL_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> $past(busyLo)); // R4
  AST_RDY_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> !rdyLowEn); // R5
  AST_INT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intN) |-> ($past(pwrDn) || $past($rose(csN)) || $past($rose(rdN)))); // R6
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busyLo && loCnt != '0 && !pwrDn) |=> busyLo); // R10
endmodule

// File: rtl/halfflash_dpath.sv
module halfflash_dpath
  import halfflash_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic [NIB_W-1:0]   hiNib,
  input  logic [NIB_W-1:0]   loNib,
  output logic [2*NIB_W-1:0] dataOut
);
  localparam int WORD_W = 2 * NIB_W;

  logic [NIB_W-1:0] hiReg, loReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else begin
      if (ctl.latchHi) hiReg <= hiNib;
      if (ctl.latchLo) loReg <= loNib;
    end
  end

  assign dataOut = ctl.driveBus ? {hiReg, loReg} : WORD_W'(0);

  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchHi |=> $stable(hiReg)); // R3
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchLo |=> $stable(loReg)); // R4
endmodule

// File: rtl/halfflash_seq.sv
module halfflash_seq
  import halfflash_pkg::*;
#(
  parameter int LO_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       modeSel,
  input  logic       pwrDn,
  input  logic [3:0] hiNib,
  input  logic [3:0] loNib,
  output logic       rdyLowEn,
  output logic       intN,
  output logic [7:0] dataOut,
  output logic       dataOe
);
  seqCtl_t ctl;

  halfflash_ctrl #(.LO_CYCLES(LO_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .modeSel(modeSel), .pwrDn(pwrDn), .ctl(ctl),
    .rdyLowEn(rdyLowEn), .intN(intN)
  );

  halfflash_dpath #(.NIB_W(4)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .hiNib(hiNib), .loNib(loNib), .dataOut(dataOut)
  );

  assign dataOe = ctl.driveBus;
endmodule

// File: tb/halfflash_seq_test.sv
module halfflash_seq_test;
  localparam int LO = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, modeSel = 1'b0, pwrDn = 1'b0;
  logic [3:0] hiNib = 4'h0, loNib = 4'h0;
  logic rdyLowEn, intN, dataOe;
  logic [7:0] dataOut;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  halfflash_seq #(.LO_CYCLES(LO)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .modeSel(modeSel), .pwrDn(pwrDn), .hiNib(hiNib), .loNib(loNib),
    .rdyLowEn(rdyLowEn), .intN(intN), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit pCs = 1, pRd = 1, pWr = 1;
  bit mArmed = 0, mDone = 0, mInt = 1, mRdy = 0;
  int mLeft = -1;
  bit [7:0] mWord = 8'h00;

  always @(posedge clk) begin
    bit endNow, csUp, csDn, rdUp, rdDn, wrUp, wrDn;
    if (!rstN) begin
      mArmed = 0; mDone = 0; mInt = 1; mRdy = 0; mLeft = -1; mWord = 0;
      pCs = 1; pRd = 1; pWr = 1;
    end else begin
      csUp = !pCs && csN;  csDn = pCs && !csN;
      rdUp = !pRd && rdN;  rdDn = pRd && !rdN;
      wrUp = !pWr && wrN;  wrDn = pWr && !wrN;
      if (pwrDn) begin
        mArmed = 0; mDone = 0; mInt = 1; mRdy = 0; mLeft = -1;
      end else begin
        endNow = (mLeft == 0);
        if (endNow) begin
          mWord[3:0] = loNib; mDone = 1; mLeft = -1; mInt = 0;
        end else if (mLeft > 0) begin
          mLeft--;
        end else if (!modeSel && rdDn && !csN) begin
          mWord[7:4] = hiNib; mLeft = LO - 1; mDone = 0;
        end else if (modeSel && wrUp && mArmed) begin
          mWord[7:4] = hiNib; mLeft = LO - 1; mDone = 0; mArmed = 0;
        end else if (modeSel && wrDn && !csN) begin
          mArmed = 1; mDone = 0;
        end
        if (!endNow && (csUp || rdUp)) mInt = 1;
        if (endNow || csUp) mRdy = 0;
        else if (!modeSel && csDn) mRdy = 1;
      end
      pCs = csN; pRd = rdN; pWr = wrN;
    end
  end

  // Per-cycle comparison, 15 ns after each rising edge
  always @(posedge clk) begin
    bit expOe;
    #15;
    if (rstN) begin
      expOe = !pwrDn && !csN && !rdN && (modeSel || mDone);
      check("R4 intN model", intN, mInt);
      check("R5 rdy model", rdyLowEn, mRdy);
      check("R7 oe model", dataOe, expOe);
      check("R2 data model", dataOut, expOe ? mWord : 8'h00);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1); #2;
    check("R1 intN", intN, 1);
    check("R1 rdy", rdyLowEn, 0);
    check("R1 oe", dataOe, 0);

    // Read-strobe mode conversion
    hiNib = 4'hA; loNib = 4'h5;
    csN = 1'b0;
    cyc(1); #2;
    check("R5 rdy after cs fall", rdyLowEn, 1);
    rdN = 1'b0; #2;
    check("R8 no drive before done", dataOe, 0);
    cyc(2); loNib = 4'hC;
    cyc(1); #2;
    check("R4 intN not yet", intN, 1);
    cyc(1); #2;
    check("R4 intN low at end", intN, 0);
    check("R5 rdy released at end", rdyLowEn, 0);
    check("R8 drive after done", dataOe, 1);
    check("R2 word", dataOut, 8'hAC);
    rdN = 1'b1;
    cyc(1); #2;
    check("R6 intN up on rd rise", intN, 1);
    csN = 1'b1;
    cyc(2);

    // cs rise clears ready without a conversion
    csN = 1'b0; cyc(2);
    csN = 1'b1; cyc(1); #2;
    check("R5 rdy cleared by cs rise", rdyLowEn, 0);

    // Write-read mode conversion
    modeSel = 1'b1; hiNib = 4'h3; loNib = 4'h9;
    cyc(1);
    csN = 1'b0; cyc(1);
    wrN = 1'b0; cyc(2);
    wrN = 1'b1; cyc(1);
    rdN = 1'b0; #2;
    check("R7 oe in write-read mode", dataOe, 1);
    check("R3 upper new lower stale", dataOut, 8'h3C);
    cyc(3); #2;
    check("R4 intN low write-read", intN, 0);
    check("R4 full word", dataOut, 8'h39);
    csN = 1'b1;
    cyc(1); #2;
    check("R6 intN up on cs rise", intN, 1);
    rdN = 1'b1; cyc(1);

    // Strobes with cs high are ignored
    hiNib = 4'hF; loNib = 4'hF;
    wrN = 1'b0; cyc(1); wrN = 1'b1; cyc(6); #2;
    check("R10 no conv with cs high", intN, 1);
    // Rising wr without an armed fall
    csN = 1'b0; wrN = 1'b0; cyc(1); // cs and wr fall together: arms
    wrN = 1'b1; cyc(6);
    rdN = 1'b0; #2;
    check("R10 armed conv word", dataOut, 8'hFF);
    rdN = 1'b1; csN = 1'b1; cyc(2);
    hiNib = 4'h1; loNib = 4'h2;
    csN = 1'b0; cyc(1);
    // wr rises from an idle-high state: no edge, no conversion
    cyc(6); rdN = 1'b0; #2;
    check("R10 unarmed word unchanged", dataOut, 8'hFF);
    rdN = 1'b1; csN = 1'b1; cyc(2);

    // Power-down
    modeSel = 1'b0; pwrDn = 1'b1;
    csN = 1'b0; cyc(1); rdN = 1'b0; #2;
    check("R9 bus released", dataOe, 0);
    cyc(LO + 2); #2;
    check("R9 intN held high", intN, 1);
    check("R9 rdy released", rdyLowEn, 0);
    rdN = 1'b1; csN = 1'b1; cyc(1);
    pwrDn = 1'b0; cyc(2);

    // Power-down inside a running conversion abandons it
    hiNib = 4'h7; loNib = 4'h7;
    csN = 1'b0; cyc(1);
    rdN = 1'b0; cyc(1);
    pwrDn = 1'b1; cyc(2);
    pwrDn = 1'b0; cyc(LO + 3); #2;
    check("R9 abandoned conv intN", intN, 1);
    check("R9 abandoned conv no drive", dataOe, 0);
    rdN = 1'b1; csN = 1'b1; cyc(2);
    modeSel = 1'b1; csN = 1'b0; cyc(1); rdN = 1'b0; #2;
    check("R9 word kept hi latched", dataOut, 8'h7F);
    rdN = 1'b1; csN = 1'b1; cyc(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule